// File: doc/BRIEF.md
# Status Byte Service Request Logic

This block assembles an instrument's 8-bit status byte from five summary flags supplied by the rest of the instrument: error queue not empty, questionable summary, message available, standard event summary and operation summary. A writable service-request enable register chooses which of these flags may ask the controller for attention. The block combines the enabled flags into a live master summary. A rising edge of that summary latches a request flag, and the request flag drives the service-request line to the controller.

Two read ports return the byte. A status query captures the byte with the live master summary in bit 6 and changes nothing. A serial poll captures the byte with the latched request flag in bit 6 and then clears that flag. The service-request line falls one cycle after the poll. Read data appears on the port's data output one clock after its strobe.

The request logic is a three-state machine. In SRQ_IDLE no request is latched and the summary is low. In SRQ_PENDING a request is latched and the line is driven. In SRQ_SERVED the controller has polled while the summary is still high. The transitions are:
- RAISE: SRQ_IDLE to SRQ_PENDING on a summary rising edge.
- RETIRE: SRQ_PENDING to SRQ_IDLE on a poll while the summary is low.
- HOLD_OFF: SRQ_PENDING to SRQ_SERVED on a poll while the summary stays high.
- RELEASE: SRQ_SERVED to SRQ_IDLE when the summary falls.
- KEEP: SRQ_PENDING stays in SRQ_PENDING when a poll and a new rising edge arrive together, or when no poll arrives.

Top module: `stb_srq_core`

## Requirements
- R1: Bits 1 and 0 of both query data and poll data always read as zero.
- R2: In both read ports, bit 2 = error queue not empty, bit 3 = questionable summary, bit 4 = message available, bit 5 = standard event summary, bit 7 = operation summary. All flags set gives 8'hBC before bit 6 is added.
- R3: Query bit 6 is the OR over bits 7, 5, 4, 3 and 2 of each status bit ANDed with the matching enable bit. Enable bit 6 never contributes to it.
- R4: A query strobe changes neither the request flag nor the service-request line.
- R5: A 0-to-1 change of the master summary, taken cycle over cycle, sets the request flag. The service-request line is high from the clock after that edge.
- R6: While the master summary stays high after a poll, no second request is raised.
- R7: A poll returns the request flag as it was before the poll in bit 6. It clears the flag, so the service-request line is low in the cycle after the poll. The other bits follow R2.
- R8: When a poll and a new summary rising edge occur in the same cycle, the request flag stays set and the line stays high.
- R9: The enable register resets to 8'h00, and a write is read back from the following cycle. After reset, both read data ports and the service-request line are zero.
- R10: A poll with no request latched returns bit 6 = 0 and leaves the request flag and the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pend | input | 1 | Error queue holds entries |
| ques_sum | input | 1 | Questionable status summary |
| msg_avail | input | 1 | Output message available |
| evt_sum | input | 1 | Standard event status summary |
| oper_sum | input | 1 | Operation status summary |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register contents |
| query_req | input | 1 | Status query strobe |
| query_data | output | 8 | Query result, bit 6 = live summary |
| poll_req | input | 1 | Serial poll strobe |
| poll_data | output | 8 | Poll result, bit 6 = latched request |
| srq | output | 1 | Service-request line, active high |

## Verification
The hardest case to produce is a poll that lands in the same cycle as a fresh rising edge of the summary. A rising edge needs the summary to have been low one cycle earlier while the request flag was still set from an earlier edge. The stimulus gets there in three steps. It raises a request, drops the only enabled flag for one cycle without polling, and then raises the flag again together with the poll strobe. The hold-off case, where the summary stays high after a poll, is reached by polling while the enabled flag stays set for several more cycles. A long random phase mixes enable writes, strobes and flag changes against the behavioural model.

// File: rtl/stb_pkg.sv
package stb_pkg;
    localparam int STB_W       = 8;
    localparam int BIT_ERRQ    = 2;
    localparam int BIT_QUES    = 3;
    localparam int BIT_MAV     = 4;
    localparam int BIT_ESUM    = 5;
    localparam int BIT_SUMMARY = 6;
    localparam int BIT_OPER    = 7;

    typedef enum logic [1:0] {
        SRQ_IDLE    = 2'd0,
        SRQ_PENDING = 2'd1,
        SRQ_SERVED  = 2'd2
    } srq_state_t;
endpackage

// File: rtl/stb_enable_reg.sv
module stb_enable_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end
    end
endmodule

// File: rtl/stb_summary.sv
module stb_summary #(
    parameter int W       = 8,
    parameter int SUM_BIT = 6
) (
    input  logic [W-1:0] stat,
    input  logic [W-1:0] enable,
    output logic         mss
);
    logic [W-1:0] masked;

    // The summary position itself is excluded so it never feeds back.
    for (genvar i = 0; i < W; i++) begin : g_mask
        if (i == SUM_BIT) begin : g_skip
            assign masked[i] = 1'b0;
        end else begin : g_use
            assign masked[i] = stat[i] & enable[i];
        end
    end

    assign mss = |masked;
endmodule

// File: rtl/stb_srq_fsm.sv
module stb_srq_fsm
    import stb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mss,
    input  logic poll,
    output logic flag,
    output logic mss_hist
);
    srq_state_t state, state_nx;
    logic       rise;

    assign rise = mss & ~mss_hist;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SRQ_IDLE;
            mss_hist <= 1'b0;
        end else begin
            state    <= state_nx;
            mss_hist <= mss;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SRQ_IDLE: begin
                if (rise) state_nx = SRQ_PENDING;              // RAISE
            end
            SRQ_PENDING: begin
                if (poll && !rise) begin
                    state_nx = mss ? SRQ_SERVED : SRQ_IDLE;    // HOLD_OFF / RETIRE
                end                                            // KEEP otherwise
            end
            SRQ_SERVED: begin
                if (rise)      state_nx = SRQ_PENDING;
                else if (!mss) state_nx = SRQ_IDLE;            // RELEASE
            end
            default: state_nx = SRQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            SRQ_PENDING: flag = 1'b1;
            SRQ_IDLE,
            SRQ_SERVED:  flag = 1'b0;
            default:     flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/stb_read_port.sv
module stb_read_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] sample,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (strobe) begin
            data <= sample;
        end
    end
endmodule

// File: rtl/stb_srq_core.sv
module stb_srq_core
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pend,
    input  logic             ques_sum,
    input  logic             msg_avail,
    input  logic             evt_sum,
    input  logic             oper_sum,
    input  logic             en_wr,
    input  logic [STB_W-1:0] en_wdata,
    output logic [STB_W-1:0] en_rdata,
    input  logic             query_req,
    output logic [STB_W-1:0] query_data,
    input  logic             poll_req,
    output logic [STB_W-1:0] poll_data,
    output logic             srq
);
    logic [STB_W-1:0] stat_byte;
    logic [STB_W-1:0] query_byte;
    logic [STB_W-1:0] poll_byte;
    logic             mss_live;
    logic             mss_hist;
    logic             req_flag;

    always_comb begin
        stat_byte            = '0;
        stat_byte[BIT_ERRQ]  = err_pend;
        stat_byte[BIT_QUES]  = ques_sum;
        stat_byte[BIT_MAV]   = msg_avail;
        stat_byte[BIT_ESUM]  = evt_sum;
        stat_byte[BIT_OPER]  = oper_sum;
    end

    stb_enable_reg #(.W(STB_W)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (en_wdata),
        .value (en_rdata)
    );

    stb_summary #(.W(STB_W), .SUM_BIT(BIT_SUMMARY)) u_summary (
        .stat   (stat_byte),
        .enable (en_rdata),
        .mss    (mss_live)
    );

    stb_srq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mss      (mss_live),
        .poll     (poll_req),
        .flag     (req_flag),
        .mss_hist (mss_hist)
    );

    always_comb begin
        query_byte              = stat_byte;
        query_byte[BIT_SUMMARY] = mss_live;
        poll_byte               = stat_byte;
        poll_byte[BIT_SUMMARY]  = req_flag;
    end

    stb_read_port #(.W(STB_W)) u_query_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (query_req),
        .sample (query_byte),
        .data   (query_data)
    );

    stb_read_port #(.W(STB_W)) u_poll_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (poll_req),
        .sample (poll_byte),
        .data   (poll_data)
    );

    assign srq = req_flag;
endmodule

// File: rtl/stb_srq_checker.sv
module stb_srq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       query_req,
    input logic       poll_req,
    input logic       en_wr,
    input logic [7:0] en_wdata,
    input logic [7:0] en_rdata,
    input logic [7:0] query_data,
    input logic [7:0] poll_data,
    input logic       srq,
    input logic       mss_live,
    input logic       mss_hist
);
    logic rise_seen;
    assign rise_seen = mss_live & ~mss_hist;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (query_data[1:0] == 2'b00) && (poll_data[1:0] == 2'b00)); // R1

    AST_QUERY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (query_req && !poll_req && !rise_seen) |=> (srq == $past(srq))); // R4

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rise_seen |=> srq); // R5

    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!srq && mss_live && mss_hist) |=> !srq); // R6

    AST_POLL_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> (poll_data[6] == $past(srq))); // R7

    AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !rise_seen) |=> !srq); // R7

    AST_POLL_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && rise_seen) |=> srq); // R8

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_rdata == $past(en_wdata))); // R9
endmodule

bind stb_srq_core stb_srq_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .query_req  (query_req),
    .poll_req   (poll_req),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .en_rdata   (en_rdata),
    .query_data (query_data),
    .poll_data  (poll_data),
    .srq        (srq),
    .mss_live   (mss_live),
    .mss_hist   (mss_hist)
);

// File: tb/stb_srq_core_test.sv
`timescale 1ns/1ps
module stb_srq_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_pend = 0, ques_sum = 0, msg_avail = 0, evt_sum = 0, oper_sum = 0;
    logic       en_wr = 0, query_req = 0, poll_req = 0;
    logic [7:0] en_wdata = 8'h00;
    logic [7:0] en_rdata, query_data, poll_data;
    logic       srq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    stb_srq_core uut (
        .clk(clk), .rst_n(rst_n),
        .err_pend(err_pend), .ques_sum(ques_sum), .msg_avail(msg_avail),
        .evt_sum(evt_sum), .oper_sum(oper_sum),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .query_req(query_req), .query_data(query_data),
        .poll_req(poll_req), .poll_data(poll_data), .srq(srq)
    );

    // Behavioural reference model
    int m_en, m_flag, m_hist, m_q, m_p;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_flag = 0; m_hist = 0; m_q = 0; m_p = 0;
        end else begin
            int st, live, edge_up;
            st = (err_pend * 4) + (ques_sum * 8) + (msg_avail * 16) + (evt_sum * 32) + (oper_sum * 128);
            live = ((st & m_en & 'hBF) != 0) ? 1 : 0;
            edge_up = live && !m_hist;
            if (query_req) m_q = st + live * 64;
            if (poll_req)  m_p = st + m_flag * 64;
            if (edge_up)       m_flag = 1;
            else if (poll_req) m_flag = 0;
            m_hist = live;
            if (en_wr) m_en = en_wdata;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 query", query_data, m_q);
            chk("R7 poll",  poll_data,  m_p);
            chk("R5 srq",   srq,        m_flag);
            chk("R9 enable", en_rdata,  m_en);
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic flags(input bit e, input bit q, input bit m, input bit v, input bit o);
        err_pend = e; ques_sum = q; msg_avail = m; evt_sum = v; oper_sum = o;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R9 reset srq", srq, 0);
        chk("R9 reset enable", en_rdata, 0);
        chk("R9 reset query", query_data, 0);
        chk("R9 reset poll", poll_data, 0);

        flags(1, 1, 1, 1, 1); query_req = 1; tick(); query_req = 0;
        chk("R2 all flags", query_data, 8'hBC);
        chk("R1 low bits", query_data[1:0], 0);
        chk("R3 no enable srq", srq, 0);

        en_wr = 1; en_wdata = 8'h40; tick(); en_wr = 0;
        query_req = 1; tick(); query_req = 0;
        chk("R3 enable bit6 ignored", query_data, 8'hBC);
        chk("R3 enable bit6 srq", srq, 0);

        flags(0, 1, 0, 0, 0); en_wr = 1; en_wdata = 8'h08; tick(); en_wr = 0;
        query_req = 1; tick(); query_req = 0;
        chk("R3 summary bit", query_data, 8'h48);
        chk("R5 raise", srq, 1);

        query_req = 1; tick(); query_req = 0;
        chk("R4 query keeps srq", srq, 1);

        poll_req = 1; tick(); poll_req = 0;
        chk("R7 poll byte", poll_data, 8'h48);
        chk("R7 srq cleared", srq, 0);

        repeat (3) tick();
        chk("R6 no rearm", srq, 0);
        poll_req = 1; tick(); poll_req = 0;
        chk("R6 poll while held", poll_data, 8'h08);

        flags(0, 0, 0, 0, 0); tick();
        flags(0, 1, 0, 0, 0); tick();
        chk("R5 second raise", srq, 1);

        flags(0, 0, 0, 0, 0); tick();
        chk("R8 pending held", srq, 1);
        flags(0, 1, 0, 0, 0); poll_req = 1; tick(); poll_req = 0;
        chk("R8 poll byte", poll_data, 8'h48);
        chk("R8 flag kept", srq, 1);
        poll_req = 1; tick(); poll_req = 0;
        chk("R7 poll after race", srq, 0);

        flags(0, 0, 0, 0, 0); tick();
        poll_req = 1; tick(); poll_req = 0;
        chk("R10 idle poll", poll_data, 8'h00);
        chk("R10 idle srq", srq, 0);
        chk("R10 enable kept", en_rdata, 8'h08);

        for (int i = 0; i < 3000; i++) begin
            flags($urandom_range(0, 7) == 0 ? ~err_pend  : err_pend,
                  $urandom_range(0, 7) == 0 ? ~ques_sum  : ques_sum,
                  $urandom_range(0, 7) == 0 ? ~msg_avail : msg_avail,
                  $urandom_range(0, 7) == 0 ? ~evt_sum   : evt_sum,
                  $urandom_range(0, 7) == 0 ? ~oper_sum  : oper_sum);
            poll_req  = ($urandom_range(0, 3) == 0);
            query_req = ($urandom_range(0, 2) == 0);
            en_wr     = ($urandom_range(0, 40) == 0);
            en_wdata  = 8'($urandom_range(0, 255));
            tick();
        end
        poll_req = 0; query_req = 0; en_wr = 0;
        tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule